// File: doc/BRIEF.md
# Indexed Display Control Register File

This block is the control-register store of a display controller. A processor reaches it through one synchronous port with an address, write data, a write strobe, a read strobe and an access-width flag. The lower half of the address space is an array of 16-bit control registers. A register is selected by its halfword index, which is the byte address shifted right by one. Two of the indices are virtual: one returns a fixed identity constant and the other returns the size of video memory in 64 KiB units. Reads past the end of the array return all ones, and writes past the end are dropped.

The upper half of the address space is a small extension window of 32-bit registers. It reports its own size and holds the framebuffer byte-order flag. The flag moves only when software writes one of two exact magic values, and every other write leaves it as it was. All register contents and the byte-order flag are driven out in parallel to the display logic downstream. Read data comes back one cycle after the read strobe.

Top module: `disp_regfile`

## Requirements
- R1: When `bus_addr[11]`=0, a write stores `bus_wdata[15:0]` into register index `bus_addr[10:1]`, whatever `bus_word` is. Register i appears on `reg_flat[16*i+15:16*i]` one cycle after the write. A read of a stored index returns its contents in `rd_data[15:0]`, with zeros in the upper 16 bits.
- R2: A read of index 0 returns the identity constant 0x0000B0C5, whatever has been written there.
- R3: A read of index 10 returns VMEM_BYTES/65536. With the default of 16 MiB this is 0x00000100.
- R4: A read of any index of NREG or more (default NREG=12) returns 0xFFFFFFFF.
- R5: A write to any index of NREG or more changes no stored register.
- R6: When `bus_addr[11]`=1 and `bus_word`=1, a read of window offset 0 returns EXT_BYTES (default 8). A read of any offset other than 0 or 4 returns zero.
- R7: A read of window offset 4 returns 0xE7D1A4B0 when the byte-order flag is big-endian (`big_endian`=1) and 0x0B4A1DE7 when it is little-endian. A write of exactly 0xE7D1A4B0 sets the flag and a write of exactly 0x0B4A1DE7 clears it. Any other write value leaves the flag unchanged.
- R8: An extension-window access with `bus_word`=0 has no effect: a write changes neither the flag nor any register, and a read returns zero.
- R9: While `rst_n` is low at a clock edge, every stored register clears to zero, the flag goes to little-endian (0), and `rd_valid` and `rd_data` clear to zero.
- R10: `rd_valid` is high exactly in the cycle after a cycle with `bus_rd` high. A read issued in the same cycle as a write returns the contents from before that write. `rd_data` holds its value when no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address; the top bit selects the extension window |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_word | input | 1 | 1 = 32-bit access, 0 = narrower access |
| rd_data | output | 32 | Read data, registered |
| rd_valid | output | 1 | High in the cycle after a read strobe |
| reg_flat | output | NREG*16 | All stored registers, index i at bits 16i+15:16i |
| big_endian | output | 1 | Framebuffer byte-order flag, 1 = big-endian |

## Verification
The embedded assertions watch on every cycle for the following: read-valid timing, out-of-range writes disturbing the array, the byte-order flag moving on a non-magic or narrow write, the flag taking the right value after a magic write, and all-ones data for out-of-range reads. Only the bench's scenarios can show the things that depend on what software wrote before. These include the values of the virtual registers even after writes to their indices, and the right register reaching the right slice of the parallel output. They also include a read returning old data when a write hits the same cycle, and the window reporting its size and zeros at undefined offsets. The bench's behavioural model follows all of these cycle by cycle.

// File: rtl/disp_regfile_pkg.sv
// Package: shared types and constants for the display control register file.
// Assumes: halfword registers, 32-bit bus data.
package disp_regfile_pkg;
    typedef logic [15:0] hword_t;
    typedef logic [31:0] word_t;

    // Identity constant returned by the virtual identity index
    localparam hword_t ID_CONST   = 16'hB0C5;
    // Magic values of the byte-order register
    localparam word_t  MAGIC_BIG  = 32'hE7D1_A4B0;
    localparam word_t  MAGIC_LIT  = 32'h0B4A_1DE7;
    // Extension window offsets
    localparam int     EXT_OFF_SIZE  = 0;
    localparam int     EXT_OFF_ORDER = 4;
endpackage

// File: rtl/disp_reg_bank.sv
// Module: disp_reg_bank
// Holds NREG halfword registers, written by index. Writes whose index is
// NREG or above match no register and are dropped.
// Assumes: wr_en is already qualified to the register window.
module disp_reg_bank
    import disp_regfile_pkg::*;
#(
    parameter int NREG  = 12,
    parameter int IDX_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  hword_t               wr_data,
    output logic [NREG*16-1:0]   regs_flat
);
    genvar gi;
    generate
        for (gi = 0; gi < NREG; gi++) begin : g_reg
            hword_t q;
            // Store the write data when this register's index is addressed
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_en && (wr_idx == IDX_W'(gi)))
                    q <= wr_data;
            end
            assign regs_flat[16*gi +: 16] = q;
        end
    endgenerate

    // R5
    oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (32'(wr_idx) >= NREG)) |=> $stable(regs_flat));
endmodule

// File: rtl/disp_ext_window.sv
// Module: disp_ext_window
// 32-bit extension window. It holds the byte-order flag and gives the
// combinational read value for each window offset.
// Assumes: wr_en is already qualified to full-width accesses of the window.
module disp_ext_window
    import disp_regfile_pkg::*;
#(
    parameter int OFF_W     = 11,
    parameter int EXT_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  off,
    input  word_t             wdata,
    output logic              big_endian,
    output word_t             rd_val
);
    logic order_hit;
    assign order_hit = (off == OFF_W'(EXT_OFF_ORDER));

    // Change the byte-order flag only on an exact magic value
    always_ff @(posedge clk) begin
        if (!rst_n)
            big_endian <= 1'b0;
        else if (wr_en && order_hit) begin
            if (wdata == MAGIC_BIG)
                big_endian <= 1'b1;
            else if (wdata == MAGIC_LIT)
                big_endian <= 1'b0;
        end
    end

    // Select the read value for the addressed offset
    always_comb begin
        if (off == OFF_W'(EXT_OFF_SIZE))
            rd_val = word_t'(EXT_BYTES);
        else if (order_hit)
            rd_val = big_endian ? MAGIC_BIG : MAGIC_LIT;
        else
            rd_val = '0;
    end

    // R7
    order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || (wdata != MAGIC_BIG && wdata != MAGIC_LIT) || !order_hit)
        |=> $stable(big_endian));
    // R7
    order_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && order_hit && wdata == MAGIC_BIG) |=> big_endian);
endmodule

// File: rtl/disp_rd_path.sv
// Module: disp_rd_path
// Registered read path. It picks the virtual constants, stored registers,
// all ones out of range, or the extension window value, one cycle after
// the read strobe.
// Assumes: the inputs show the state before any write in the same cycle.
module disp_rd_path
    import disp_regfile_pkg::*;
#(
    parameter int NREG       = 12,
    parameter int IDX_W      = 10,
    parameter int ID_IDX     = 0,
    parameter int VMEM_IDX   = 10,
    parameter int VMEM_UNITS = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd,
    input  logic                ext_sel,
    input  logic                ext_ok,
    input  logic [IDX_W-1:0]    idx,
    input  logic [NREG*16-1:0]  regs_flat,
    input  word_t               ext_val,
    output word_t               rd_data,
    output logic                rd_valid
);
    word_t  reg_val;
    hword_t stored;

    // Pick the stored register addressed by the index
    always_comb begin
        stored = '0;
        for (int i = 0; i < NREG; i++)
            if (idx == IDX_W'(i)) stored = regs_flat[16*i +: 16];
    end

    // Resolve virtual indices and the out-of-range case
    always_comb begin
        if (idx == IDX_W'(ID_IDX))
            reg_val = {16'h0, ID_CONST};
        else if (idx == IDX_W'(VMEM_IDX))
            reg_val = word_t'(VMEM_UNITS);
        else if (32'(idx) < NREG)
            reg_val = {16'h0, stored};
        else
            reg_val = '1;
    end

    // Register the read data and its valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd;
            if (rd)
                rd_data <= ext_sel ? (ext_ok ? ext_val : '0) : reg_val;
        end
    end

    // R10
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rd_valid);
    // R10
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (!rd_valid && $stable(rd_data)));
    // R4
    oob_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !ext_sel && 32'(idx) >= NREG && 32'(idx) != ID_IDX
         && 32'(idx) != VMEM_IDX) |=> (rd_data == 32'hFFFF_FFFF));
endmodule

// File: rtl/disp_regfile.sv
// Module: disp_regfile (top)
// Decodes the bus into the halfword register window (top address bit 0)
// and the 32-bit extension window (top address bit 1), then wires the
// register bank, extension window and read path together.
// Assumes: one access per cycle; reads see the state from before a write
// in the same cycle.
module disp_regfile
    import disp_regfile_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NREG       = 12,
    parameter int ID_IDX     = 0,
    parameter int VMEM_IDX   = 10,
    parameter int VMEM_BYTES = 16 * 1024 * 1024,
    parameter int EXT_BYTES  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic                 bus_word,
    output logic [31:0]          rd_data,
    output logic                 rd_valid,
    output logic [NREG*16-1:0]   reg_flat,
    output logic                 big_endian
);
    localparam int IDX_W      = ADDR_W - 2;
    localparam int OFF_W      = ADDR_W - 1;
    localparam int VMEM_UNITS = VMEM_BYTES / 65536;

    logic             ext_sel, ext_ok;
    logic [IDX_W-1:0] reg_idx;
    logic [OFF_W-1:0] ext_off;
    word_t            ext_val;

    assign ext_sel = bus_addr[ADDR_W-1];
    assign ext_ok  = ext_sel && bus_word;
    assign reg_idx = bus_addr[ADDR_W-2:1];
    assign ext_off = bus_addr[OFF_W-1:0];

    disp_reg_bank #(.NREG(NREG), .IDX_W(IDX_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr && !ext_sel),
        .wr_idx    (reg_idx),
        .wr_data   (bus_wdata[15:0]),
        .regs_flat (reg_flat)
    );

    disp_ext_window #(.OFF_W(OFF_W), .EXT_BYTES(EXT_BYTES)) u_ext (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr && ext_ok),
        .off        (ext_off),
        .wdata      (bus_wdata),
        .big_endian (big_endian),
        .rd_val     (ext_val)
    );

    disp_rd_path #(
        .NREG(NREG), .IDX_W(IDX_W), .ID_IDX(ID_IDX),
        .VMEM_IDX(VMEM_IDX), .VMEM_UNITS(VMEM_UNITS)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (bus_rd),
        .ext_sel   (ext_sel),
        .ext_ok    (ext_ok),
        .idx       (reg_idx),
        .regs_flat (reg_flat),
        .ext_val   (ext_val),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    // R8
    narrow_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ext_sel && !bus_word) |=> ($stable(big_endian) && $stable(reg_flat)));
endmodule

// File: tb/disp_regfile_bench.sv
`timescale 1ns/1ps
module disp_regfile_bench;
    localparam int NREG = 12;
    localparam logic [31:0] MB = 32'hE7D1_A4B0;
    localparam logic [31:0] ML = 32'h0B4A_1DE7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [11:0] b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic b_wr = 1'b0, b_rd = 1'b0, b_word = 1'b0;
    logic [31:0] rd_data;
    logic rd_valid;
    logic [NREG*16-1:0] reg_flat;
    logic big_endian;

    always #2.5 clk = ~clk;

    disp_regfile u_disp_regfile (
        .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wdata(b_wdata),
        .bus_wr(b_wr), .bus_rd(b_rd), .bus_word(b_word),
        .rd_data(rd_data), .rd_valid(rd_valid), .reg_flat(reg_flat),
        .big_endian(big_endian)
    );

    int checks = 0, errors = 0;
    logic [15:0] m_regs [NREG];
    logic m_be = 0, m_rvalid = 0, chk_en = 0, done = 0;
    logic [31:0] m_rdata = 0;
    string m_tag = "R10";

    // Behavioural reference model: read first (pre-write state), then write
    always @(posedge clk) begin
        int idx, off;
        idx = int'(b_addr[10:1]);
        off = int'(b_addr[10:0]);
        if (!rst_n) begin
            foreach (m_regs[i]) m_regs[i] = 16'h0;
            m_be = 0; m_rvalid = 0; m_rdata = 0;
        end else begin
            m_rvalid = b_rd;
            if (b_rd) begin
                if (b_addr[11]) begin
                    if (!b_word) begin m_rdata = 0; m_tag = "R8"; end
                    else if (off == 0) begin m_rdata = 8; m_tag = "R6"; end
                    else if (off == 4) begin m_rdata = m_be ? MB : ML; m_tag = "R7"; end
                    else begin m_rdata = 0; m_tag = "R6"; end
                end else if (idx == 0) begin m_rdata = 32'h0000B0C5; m_tag = "R2"; end
                else if (idx == 10) begin m_rdata = 32'h100; m_tag = "R3"; end
                else if (idx < NREG) begin m_rdata = {16'h0, m_regs[idx]}; m_tag = "R1"; end
                else begin m_rdata = 32'hFFFF_FFFF; m_tag = "R4"; end
            end
            if (b_wr) begin
                if (!b_addr[11]) begin
                    if (idx < NREG) m_regs[idx] = b_wdata[15:0];
                end else if (b_word && off == 4) begin
                    if (b_wdata == MB) m_be = 1;
                    else if (b_wdata == ML) m_be = 0;
                end
            end
            chk_en = 1;
        end
    end

    task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Compare the design with the model on every clock, away from the edge
    always @(negedge clk) begin
        logic [NREG*16-1:0] exp_flat;
        if (chk_en && !done) begin
            for (int i = 0; i < NREG; i++) exp_flat[16*i +: 16] = m_regs[i];
            check("R10 rd_valid", 256'(rd_valid), 256'(m_rvalid));
            check({m_tag, " rd_data"}, 256'(rd_data), 256'(m_rdata));
            check("R1 R5 reg_flat", 256'(reg_flat), 256'(exp_flat));
            check("R7 R8 big_endian", 256'(big_endian), 256'(m_be));
        end
    end

    task automatic op(input logic wr, input logic rd, input logic word,
                      input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        b_wr = wr; b_rd = rd; b_word = word; b_addr = a; b_wdata = d;
    endtask

    task automatic idle();
        op(0, 0, 0, 12'h0, 32'h0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 reset rd_valid", 256'(rd_valid), 256'(0));
        check("R9 reset rd_data", 256'(rd_data), 256'(0));
        check("R9 reset reg_flat", 256'(reg_flat), 256'(0));
        check("R9 reset big_endian", 256'(big_endian), 256'(0));
        rst_n = 1;
        // R1 write all stored registers, narrow and wide
        for (int i = 0; i < NREG; i++)
            op(1, 0, i[0], 12'(2 * i), 32'hA500_0000 | (32'h1111 * i + 32'h3C));
        // R1 R2 R3 R4 read back indices 0..15 and far indices
        for (int i = 0; i < 16; i++) op(0, 1, 0, 12'(2 * i), 0);
        op(0, 1, 0, 12'h7FE, 0);
        op(0, 1, 0, 12'h019, 0);   // odd byte address, index 12
        // R5 out-of-range writes
        op(1, 0, 0, 12'h018, 32'hDEAD);
        op(1, 0, 1, 12'h400, 32'hBEEF);
        idle();
        // R6 extension reads
        op(0, 1, 1, 12'h800, 0);
        op(0, 1, 1, 12'h808, 0);
        op(0, 1, 1, 12'h8FC, 0);
        // R7 byte order: bad, big, bad, little
        op(0, 1, 1, 12'h804, 0);
        op(1, 0, 1, 12'h804, 32'hE7D1_A4B1);
        op(1, 1, 1, 12'h804, MB);   // read returns pre-write (R10)
        op(0, 1, 1, 12'h804, 0);
        op(1, 0, 1, 12'h804, 32'h0);
        op(1, 0, 1, 12'h800, ML);   // wrong offset
        op(0, 1, 1, 12'h804, 0);
        op(1, 0, 1, 12'h804, ML);
        op(0, 1, 1, 12'h804, 0);
        // R8 narrow window accesses
        op(1, 0, 0, 12'h804, MB);
        op(0, 1, 0, 12'h804, 0);
        op(0, 1, 0, 12'h800, 0);
        // R10 read with same-cycle write, then rd_data hold
        op(1, 1, 0, 12'h006, 32'h7777);
        op(0, 1, 0, 12'h006, 0);
        idle(); idle();
        // R2 R3 virtual indices after writes
        op(1, 0, 0, 12'h000, 32'h1234);
        op(1, 0, 0, 12'h014, 32'h5678);
        op(0, 1, 0, 12'h000, 0);
        op(0, 1, 0, 12'h014, 0);
        // R9 reset mid-run
        op(1, 0, 1, 12'h804, MB);
        idle();
        rst_n = 0;
        idle(); idle();
        rst_n = 1;
        op(0, 1, 0, 12'h004, 0);
        idle(); idle();
        finish_run();
    end
endmodule